// File: doc/BRIEF.md
# Chained Scan Control and Status Rings

This block is the scan controller that sits on each chip of a daisy-chained system scan bus. Every chip in the chain takes its scan data and strobes from the chip before it, or from the service processor at the head of the chain. Each chip holds two fixed-length rings. The 14-bit control ring is filled serially and then committed in parallel into the chip's control registers. The 47-bit status ring is filled in parallel from the chip's state and then shifted out toward the service processor.

One of the status bits is a temperature alarm. The block compares a parallel temperature reading against a threshold that the console writes into the control registers. When the reading exceeds the threshold, the alarm trips and stays set until software writes a clear bit. When neither ring is selected, a one-bit bypass stage keeps the chain short. Scan-out is retimed on the falling clock edge, so the next chip in the chain always samples a settled bit.

Top module: `scan_ring_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the control registers, both rings, the bypass stage, the alarm flag and scan_out to zero.
- R2: ring_sel encodes the active path: 2'b01 selects the control ring, 2'b10 selects the status ring, and 2'b00 or 2'b11 selects a one-bit bypass stage whose value reaches scan_out one shift later.
- R3: Each shift clock moves the selected ring one place toward bit 0. scan_in enters at the top bit and bit 0 leaves first. A 14-bit control word therefore lands in place after 14 shifts with its bit 0 sent first.
- R4: load_en copies the whole control ring into ctrl_q in one clock, whatever ring_sel is, and leaves the ring unchanged. When load_en and a control-ring shift fall in the same cycle, ctrl_q receives the contents from before the shift. While load_en is low, ctrl_q holds.
- R5: capture_en fills the 47-bit status ring in one clock. Bit 0 is the alarm flag, bits 8:1 are temp_in and bits 46:9 are status_in. If capture_en and a status-ring shift fall in the same cycle, the capture wins.
- R6: A ring that is not selected keeps its contents while shift_en clocks the other path.
- R7: ctrl_q[7:0] is the temperature threshold. The alarm sets at the clock edge where temp_in is strictly greater than the threshold. A reading equal to the threshold does not trip it.
- R8: Once set, the alarm stays set after the temperature falls. While ctrl_q[8] (the clear bit) is 1, the alarm is held at 0, and this clear takes priority over a new trip.
- R9: scan_out changes only on the falling clock edge. It presents the bit 0 of the selected path that resulted from the preceding rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_in | input | 1 | Serial data from the previous chip or service processor |
| ring_sel | input | 2 | Path select: 01 control, 10 status, 00/11 bypass |
| shift_en | input | 1 | Shift the selected path by one bit |
| load_en | input | 1 | Commit control ring to control registers |
| capture_en | input | 1 | Parallel-fill the status ring |
| temp_in | input | 8 | Parallel temperature reading |
| status_in | input | 38 | Other chip status bits for the status ring |
| scan_out | output | 1 | Serial data to the next chip, updated on falling edge |
| ctrl_q | output | 14 | Control register contents |
| temp_alarm | output | 1 | Sticky over-temperature flag |

## Verification
Two functions can meet on the same clock edge: a control-ring shift together with a load commit, and a status-ring shift together with a capture. The bench drives both strobes high in one cycle. For the load case it checks that ctrl_q holds the word from before the shift and that the ring has still moved by one place, which it confirms by reading the ring back out. For the capture case it reads back the status ring and checks that it holds exactly the captured vector, with no shifted bit mixed in. A third meeting, where the clear bit is held while the temperature is over the threshold, is judged by checking that the alarm stays low.

// File: rtl/scan_ring_pkg.sv
package scan_ring_pkg;

    localparam int CTRL_LEN = 14;
    localparam int STAT_LEN = 47;
    localparam int TEMP_W   = 8;
    localparam int EXT_W    = STAT_LEN - 1 - TEMP_W;
    localparam int SPARE_W  = CTRL_LEN - TEMP_W - 1;

    typedef enum logic [1:0] {
        SEL_BYP_LO = 2'b00,
        SEL_CTRL   = 2'b01,
        SEL_STAT   = 2'b10,
        SEL_BYP_HI = 2'b11
    } ring_sel_e;

    typedef struct packed {
        logic [SPARE_W-1:0] spare;
        logic               alarm_clr;
        logic [TEMP_W-1:0]  thresh;
    } ctrl_word_t;

    typedef struct packed {
        logic [EXT_W-1:0]  ext;
        logic [TEMP_W-1:0] temp;
        logic              alarm;
    } stat_word_t;

    function automatic logic temp_over(input logic [TEMP_W-1:0] reading,
                                       input logic [TEMP_W-1:0] limit);
        return reading > limit;
    endfunction

endpackage

// File: rtl/scan_shift_reg.sv
module scan_shift_reg #(
    parameter int LEN = 14
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           shift_en,
    input  logic           par_en,
    input  logic [LEN-1:0] par_in,
    input  logic           ser_in,
    output logic [LEN-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (par_en)
            q <= par_in;
        else if (shift_en)
            q <= {ser_in, q[LEN-1:1]};
    end

    assert_ring_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!shift_en && !par_en) |=> $stable(q));

    assert_shift_entry_R3: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !par_en) |=> (q[LEN-1] == $past(ser_in)));

    assert_par_fill_R5: assert property (@(posedge clk) disable iff (rst)
        par_en |=> (q == $past(par_in)));

endmodule

// File: rtl/scan_temp_trip.sv
module scan_temp_trip
    import scan_ring_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [TEMP_W-1:0] temp,
    input  logic [TEMP_W-1:0] thresh,
    input  logic              clr,
    output logic              alarm
);

    logic over;
    assign over = temp_over(temp, thresh);

    always_ff @(posedge clk) begin
        if (rst || clr)
            alarm <= 1'b0;
        else if (over)
            alarm <= 1'b1;
    end

    assert_trip_R7: assert property (@(posedge clk) disable iff (rst)
        (over && !clr) |=> alarm);

    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (alarm && !clr) |=> alarm);

    assert_clear_wins_R8: assert property (@(posedge clk) disable iff (rst)
        clr |=> !alarm);

endmodule

// File: rtl/scan_out_stage.sv
module scan_out_stage
    import scan_ring_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] ring_sel,
    input  logic       shift_en,
    input  logic       scan_in,
    input  logic       ctrl_lsb,
    input  logic       stat_lsb,
    output logic       scan_out
);

    ring_sel_e sel;
    logic      byp_q;
    logic      path_bit;

    assign sel = ring_sel_e'(ring_sel);

    always_ff @(posedge clk) begin
        if (rst)
            byp_q <= 1'b0;
        else if (shift_en && (sel == SEL_BYP_LO || sel == SEL_BYP_HI))
            byp_q <= scan_in;
    end

    always_comb begin
        case (sel)
            SEL_CTRL: path_bit = ctrl_lsb;
            SEL_STAT: path_bit = stat_lsb;
            default:  path_bit = byp_q;
        endcase
    end

    always_ff @(negedge clk) begin
        if (rst)
            scan_out <= 1'b0;
        else
            scan_out <= path_bit;
    end

    assert_bypass_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_CTRL || sel == SEL_STAT || !shift_en) |=> $stable(byp_q));

endmodule

// File: rtl/scan_ring_ctrl.sv
module scan_ring_ctrl
    import scan_ring_pkg::*;
#(
    parameter int C_LEN = CTRL_LEN,
    parameter int S_LEN = STAT_LEN,
    parameter int T_W   = TEMP_W,
    localparam int X_W  = S_LEN - 1 - T_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scan_in,
    input  logic [1:0]       ring_sel,
    input  logic             shift_en,
    input  logic             load_en,
    input  logic             capture_en,
    input  logic [T_W-1:0]   temp_in,
    input  logic [X_W-1:0]   status_in,
    output logic             scan_out,
    output logic [C_LEN-1:0] ctrl_q,
    output logic             temp_alarm
);

    logic [C_LEN-1:0] ctrl_ring;
    logic [S_LEN-1:0] stat_ring;
    logic             ctrl_shift;
    logic             stat_shift;
    ctrl_word_t       ctrl_fields;
    stat_word_t       cap_word;

    assign ctrl_shift = shift_en && (ring_sel_e'(ring_sel) == SEL_CTRL);
    assign stat_shift = shift_en && (ring_sel_e'(ring_sel) == SEL_STAT);

    assign ctrl_fields = ctrl_word_t'(ctrl_q);

    always_comb begin
        cap_word.alarm = temp_alarm;
        cap_word.temp  = temp_in;
        cap_word.ext   = status_in;
    end

    scan_shift_reg #(.LEN(C_LEN)) u_ctrl_ring (
        .clk      (clk),
        .rst      (rst),
        .shift_en (ctrl_shift),
        .par_en   (1'b0),
        .par_in   ({C_LEN{1'b0}}),
        .ser_in   (scan_in),
        .q        (ctrl_ring)
    );

    scan_shift_reg #(.LEN(S_LEN)) u_stat_ring (
        .clk      (clk),
        .rst      (rst),
        .shift_en (stat_shift),
        .par_en   (capture_en),
        .par_in   (S_LEN'(cap_word)),
        .ser_in   (scan_in),
        .q        (stat_ring)
    );

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (load_en)
            ctrl_q <= ctrl_ring;
    end

    scan_temp_trip u_trip (
        .clk    (clk),
        .rst    (rst),
        .temp   (temp_in),
        .thresh (ctrl_fields.thresh),
        .clr    (ctrl_fields.alarm_clr),
        .alarm  (temp_alarm)
    );

    scan_out_stage u_out (
        .clk      (clk),
        .rst      (rst),
        .ring_sel (ring_sel),
        .shift_en (shift_en),
        .scan_in  (scan_in),
        .ctrl_lsb (ctrl_ring[0]),
        .stat_lsb (stat_ring[0]),
        .scan_out (scan_out)
    );

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (ctrl_q == '0 && !temp_alarm && ctrl_ring == '0 && stat_ring == '0));

    assert_load_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> $stable(ctrl_q));

    assert_load_copy_R4: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (ctrl_q == $past(ctrl_ring)));

    assert_capture_alarm_R5: assert property (@(posedge clk) disable iff (rst)
        capture_en |=> (stat_ring[0] == $past(temp_alarm)));

endmodule

// File: tb/scan_ring_ctrl_tb.sv
module scan_ring_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scan_in = 1'b0;
    logic [1:0]  ring_sel = 2'b00;
    logic        shift_en = 1'b0;
    logic        load_en = 1'b0;
    logic        capture_en = 1'b0;
    logic [7:0]  temp_in = 8'd0;
    logic [37:0] status_in = '0;
    logic        scan_out;
    logic [13:0] ctrl_q;
    logic        temp_alarm;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // entries: {threshold[16:9], temperature[8:1], expected alarm[0]}
    localparam logic [16:0] TRIP_VEC [0:6] = '{
        {8'd100, 8'd101, 1'b1},
        {8'd100, 8'd100, 1'b0},
        {8'd100, 8'd99,  1'b0},
        {8'd0,   8'd1,   1'b1},
        {8'd255, 8'd255, 1'b0},
        {8'd254, 8'd255, 1'b1},
        {8'd0,   8'd0,   1'b0}
    };

    always #10 clk = ~clk;

    scan_ring_ctrl u_dut (
        .clk        (clk),
        .rst        (rst),
        .scan_in    (scan_in),
        .ring_sel   (ring_sel),
        .shift_en   (shift_en),
        .load_en    (load_en),
        .capture_en (capture_en),
        .temp_in    (temp_in),
        .status_in  (status_in),
        .scan_out   (scan_out),
        .ctrl_q     (ctrl_q),
        .temp_alarm (temp_alarm)
    );

    task automatic step();
        @(posedge clk);
        #12;
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic shift_in(input logic [63:0] v, input int len);
        shift_en = 1'b1;
        for (int i = 0; i < len; i++) begin
            scan_in = v[i];
            step();
        end
        shift_en = 1'b0;
        scan_in  = 1'b0;
    endtask

    task automatic read_ring(input int len, output logic [63:0] v);
        v = '0;
        shift_en = 1'b0;
        step();
        v[0] = scan_out;
        shift_en = 1'b1;
        scan_in  = 1'b0;
        for (int i = 1; i < len; i++) begin
            step();
            v[i] = scan_out;
        end
        shift_en = 1'b0;
    endtask

    task automatic write_ctrl(input logic [13:0] w);
        ring_sel = 2'b01;
        shift_in({50'd0, w}, 14);
        load_en = 1'b1;
        step();
        load_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] rv;
        logic [63:0] exp_stat;

        repeat (3) step();
        rst = 1'b0;

        // R1 reset state
        check("R1 ctrl_q", 64'(ctrl_q), 64'h0);
        check("R1 alarm", 64'(temp_alarm), 64'h0);
        check("R1 scan_out", 64'(scan_out), 64'h0);

        // R3 R4 write and commit, ring unchanged by load
        write_ctrl(14'h2A5C);
        check("R3 R4 ctrl_q after load", 64'(ctrl_q), 64'h2A5C);
        ring_sel = 2'b01;
        read_ring(14, rv);
        check("R4 ring unchanged by load", rv, 64'h2A5C);

        // R6 control ring holds while status ring shifts
        ring_sel = 2'b01;
        shift_in(64'h1337, 14);
        ring_sel = 2'b10;
        shift_in(64'hFFFFF, 20);
        ring_sel = 2'b01;
        read_ring(14, rv);
        check("R6 ctrl ring held", rv, 64'h1337);
        check("R4 ctrl_q held without load", 64'(ctrl_q), 64'h2A5C);

        // R2 bypass paths
        ring_sel = 2'b00;
        shift_in(64'h1, 1);
        check("R2 bypass 00 one", 64'(scan_out), 64'h1);
        shift_in(64'h0, 1);
        check("R2 bypass 00 zero", 64'(scan_out), 64'h0);
        ring_sel = 2'b11;
        shift_in(64'h1, 1);
        check("R2 bypass 11 one", 64'(scan_out), 64'h1);
        shift_in(64'h0, 1);

        // R9 scan_out moves only at the falling edge
        scan_in  = 1'b1;
        shift_en = 1'b1;
        @(posedge clk);
        #3;
        check("R9 before falling edge", 64'(scan_out), 64'h0);
        #9;
        check("R9 after falling edge", 64'(scan_out), 64'h1);
        shift_en = 1'b0;
        scan_in  = 1'b0;

        // R7 threshold compare table
        for (int k = 0; k < 7; k++) begin
            temp_in = 8'd0;
            write_ctrl({5'd0, 1'b1, TRIP_VEC[k][16:9]});
            step();
            write_ctrl({5'd0, 1'b0, TRIP_VEC[k][16:9]});
            temp_in = TRIP_VEC[k][8:1];
            step();
            check("R7 strict compare", 64'(temp_alarm), 64'(TRIP_VEC[k][0]));
        end

        // R8 sticky alarm, R5 capture with alarm
        temp_in = 8'd0;
        write_ctrl({5'd0, 1'b0, 8'd10});
        temp_in = 8'd50;
        step();
        check("R7 trip", 64'(temp_alarm), 64'h1);
        temp_in = 8'd0;
        step();
        step();
        check("R8 sticky after cool", 64'(temp_alarm), 64'h1);

        ring_sel   = 2'b10;
        status_in  = 38'h2A_1234_5678;
        temp_in    = 8'd50;
        capture_en = 1'b1;
        step();
        capture_en = 1'b0;
        exp_stat = {17'd0, 38'h2A_1234_5678, 8'd50, 1'b1};
        read_ring(47, rv);
        check("R5 capture layout", rv, exp_stat);

        temp_in = 8'd0;
        write_ctrl({5'd0, 1'b1, 8'd10});
        step();
        check("R8 clear bit", 64'(temp_alarm), 64'h0);
        temp_in = 8'd200;
        step();
        check("R8 clear beats trip", 64'(temp_alarm), 64'h0);
        temp_in = 8'd0;

        // R4 load and shift in the same cycle
        ring_sel = 2'b01;
        shift_in(64'h0F0F, 14);
        shift_en = 1'b1;
        load_en  = 1'b1;
        scan_in  = 1'b1;
        step();
        shift_en = 1'b0;
        load_en  = 1'b0;
        scan_in  = 1'b0;
        check("R4 load takes pre-shift word", 64'(ctrl_q), 64'h0F0F);
        read_ring(14, rv);
        check("R4 ring still shifted", rv, 64'h2787);

        // R5 capture and shift in the same cycle (alarm held clear by bit 8)
        ring_sel   = 2'b10;
        status_in  = 38'h15_5555_AAAA;
        temp_in    = 8'h3C;
        capture_en = 1'b1;
        shift_en   = 1'b1;
        scan_in    = 1'b1;
        step();
        capture_en = 1'b0;
        shift_en   = 1'b0;
        scan_in    = 1'b0;
        exp_stat = {17'd0, 38'h15_5555_AAAA, 8'h3C, 1'b0};
        read_ring(47, rv);
        check("R5 capture wins over shift", rv, exp_stat);

        // R4 load acts with status ring selected; ctrl ring now 14'h0001
        ring_sel = 2'b10;
        load_en  = 1'b1;
        step();
        load_en  = 1'b0;
        check("R4 load independent of select", 64'(ctrl_q), 64'h0001);

        // R1 reset after activity
        rst = 1'b1;
        step();
        step();
        rst = 1'b0;
        check("R1 ctrl_q after reset", 64'(ctrl_q), 64'h0);
        check("R1 alarm after reset", 64'(temp_alarm), 64'h0);
        check("R1 scan_out after reset", 64'(scan_out), 64'h0);
        ring_sel = 2'b10;
        temp_in  = 8'd0;
        read_ring(47, rv);
        check("R1 status ring after reset", rv, 64'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule